// File: doc/BRIEF.md
# Cache-Miss Block Read Request Issuer

This block sits between a secondary cache controller and a split-transaction system bus. The controller presents a line miss, which comes from an instruction fetch, load, store or prefetch to cacheable space. The miss carries a physical address, a read cause, a target code, the cache way and the state the line held before the miss. The block holds that miss until every issue condition is true. It then accepts the miss and, in the same cycle, tells the controller to mark the line Invalid. If the line was dirty-exclusive, it also schedules a write-back of that line. On the next clock it drives a single address cycle on the 12-bit command bus and the 64-bit address/data bus, strobed by an active-low valid line.

Each request takes the lowest-numbered free request tag out of a pool of eight. The tag stays in use until a completion response (data, negative-acknowledge or error) names it. A completion never brings the line back: after a negative-acknowledge or error the line stays Invalid. A request may issue only under these conditions: the bus interface is master; the active-low read-ready input was low two clocks before the address cycle; no valid outgoing-buffer entry or pending external coherency request covers the same cache line; the number of tags in use is below a programmable ceiling; and a tag is free.

Top module: `blkrd_issuer`

## Requirements
- R1: After reset the valid strobe is high, both buses are zero, all eight tags are free, and `miss_ready` stays low in the first cycle after reset, because no read-ready history exists yet.
- R2: In an address cycle the command bus carries bit 11 = 0, bits 10:8 = tag, bits 7:5 = block-read code 3'b010, bits 4:3 = cause, bits 2:1 = former line state, and bit 0 = 1.
- R3: In an address cycle the address/data bus carries bits 63:60 = target, bit 57 = way, bits 39:0 = physical address, and zero in bits 59:58 and 56:40.
- R4: A miss accepted in cycle c (`miss_valid` and `miss_ready` both high) produces exactly one address cycle, in cycle c+1. In any cycle with the strobe high, both buses are zero.
- R5: An address cycle in cycle k happens only if `rd_rdy_n` was low in cycle k-2. Equivalently, `miss_ready` in cycle c requires `rd_rdy_n` low in cycle c-1.
- R6: No miss is accepted while `master_state` is low.
- R7: No miss is accepted while a valid outgoing-buffer entry matches the miss address in bits 39:7, which is the 128-byte line. An entry that differs in those bits, or is not valid, does not block.
- R8: No miss is accepted while a valid pending coherency address matches the miss address in bits 39:7.
- R9: No miss is accepted unless the number of tags in use is below `req_max`.
- R10: Each accepted miss gets the lowest-numbered free tag. That tag is not handed out again until it is released. With no tag free, no miss is accepted.
- R11: A completion with `cmp_valid` high releases tag `cmp_tag`, which then becomes available to the next miss.
- R12: In the cycle a miss is accepted, `inv_en` pulses together with the miss address and way. `wb_en` pulses in that same cycle only when the former state is dirty-exclusive (2'b11). States 2'b00 invalid, 2'b01 shared and 2'b10 clean-exclusive give no write-back.
- R13: While any condition is false, `miss_ready` is low, a presented miss is held, and the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| miss_valid | input | 1 | A miss is presented |
| miss_ready | output | 1 | Miss accepted this cycle when valid |
| miss_addr | input | 40 | Physical address of the miss |
| miss_cause | input | 2 | Read cause |
| miss_target | input | 4 | Target indication |
| miss_way | input | 1 | Cache way of the line |
| miss_state | input | 2 | Former line state |
| master_state | input | 1 | Interface currently holds bus mastership |
| rd_rdy_n | input | 1 | Active-low read-ready from the system |
| obuf_valid | input | OBUF_N | Outgoing-buffer entry valid flags |
| obuf_addr | input | OBUF_N*40 | Outgoing-buffer entry addresses |
| coh_valid | input | COH_N | Pending coherency request valid flags |
| coh_addr | input | COH_N*40 | Pending coherency request addresses |
| req_max | input | CNT_W | Ceiling on tags in use |
| cmp_valid | input | 1 | Completion response arrives |
| cmp_tag | input | 3 | Tag named by the completion |
| sys_cmd | output | 12 | Command bus |
| sys_ad | output | 64 | Address/data bus |
| sys_val_n | output | 1 | Active-low address cycle strobe |
| inv_en | output | 1 | Set the line to Invalid |
| inv_addr | output | 40 | Address of the line to invalidate |
| inv_way | output | 1 | Way of the line to invalidate |
| wb_en | output | 1 | Schedule a write-back |
| wb_addr | output | 40 | Address of the line to write back |
| wb_way | output | 1 | Way of the line to write back |

## Verification
The hardest case to reach from the ports is the read-ready lag. A single high pulse on `rd_rdy_n` must block exactly the acceptance one cycle later. The stimulus therefore holds the miss away while the pulse is driven, presents the miss in the following cycle, and checks that it is refused. It then checks that the same miss is accepted one cycle after that. Tag exhaustion is reached by issuing eight misses without completions, and the tag returned later proves which slot was released.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;
  localparam int PA_W = 40;
  localparam int CMD_W = 12;
  localparam int AD_W = 64;
  localparam logic [2:0] CMD_BLOCK_READ = 3'b010;

  typedef enum logic [1:0] {
    LS_INVALID  = 2'b00,
    LS_SHARED   = 2'b01,
    LS_CLEAN_EX = 2'b10,
    LS_DIRTY_EX = 2'b11
  } line_state_e;

  // Command word of the block-read address cycle.
  function automatic logic [CMD_W-1:0] cmd_word(input logic [2:0] tag,
                                                input logic [1:0] cause,
                                                input logic [1:0] st);
    return {1'b0, tag, CMD_BLOCK_READ, cause, st, 1'b1};
  endfunction

  // Address/data word of the block-read address cycle.
  function automatic logic [AD_W-1:0] ad_word(input logic [3:0] target,
                                              input logic way,
                                              input logic [PA_W-1:0] addr);
    return {target, 2'b00, way, 17'd0, addr};
  endfunction
endpackage

// File: rtl/blkrd_rdy_hist.sv
module blkrd_rdy_hist #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_n,
  output logic rdy_ok
);
  // The address cycle is one register after acceptance, so the history
  // needs LAG-1 stages to present the value from LAG cycles before the bus.
  localparam int STAGES = LAG - 1;
  logic [STAGES-1:0] hist_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b1;
        else        hist_q <= rdy_n;
      end
      AST_RDY_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_ok |-> $past(rdy_n) == 1'b0); // R5
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= {hist_q[STAGES-2:0], rdy_n};
      end
    end
  endgenerate

  assign rdy_ok = ~hist_q[STAGES-1];
endmodule

// File: rtl/blkrd_conflict.sv
module blkrd_conflict #(
  parameter int PA_W   = 40,
  parameter int LINE_W = 7,
  parameter int N      = 4
) (
  input  logic [PA_W-1:0]   probe,
  input  logic [N-1:0]      vld,
  input  logic [N*PA_W-1:0] addrs,
  output logic              hit
);
  function automatic logic same_line(input logic [PA_W-1:0] a,
                                     input logic [PA_W-1:0] b);
    return a[PA_W-1:LINE_W] == b[PA_W-1:LINE_W];
  endfunction

  logic [N-1:0] match;

  generate
    for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match[i] = vld[i] && same_line(probe, addrs[i*PA_W +: PA_W]);
    end
  endgenerate

  assign hit = |match;
endmodule

// File: rtl/blkrd_tag_pool.sv
module blkrd_tag_pool #(
  parameter int TAGS  = 8,
  parameter int TAG_W = $clog2(TAGS),
  parameter int CNT_W = $clog2(TAGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             any_free,
  output logic [TAG_W-1:0] pick,
  output logic [CNT_W-1:0] busy_cnt
);
  logic [TAGS-1:0] free_q;
  logic [TAGS-1:0] rel_mask;
  logic [TAGS-1:0] alloc_mask;

  function automatic logic [TAG_W-1:0] lowest_set(input logic [TAGS-1:0] m);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = TAGS - 1; i >= 0; i--) if (m[i]) r = TAG_W'(i);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] zeros_count(input logic [TAGS-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < TAGS; i++) c = c + CNT_W'(!m[i]);
    return c;
  endfunction

  always_comb begin
    rel_mask = '0;
    if (rel_valid) rel_mask[rel_tag] = 1'b1;
    alloc_mask = '0;
    if (alloc) alloc_mask[pick] = 1'b1;
  end

  assign any_free = |free_q;
  assign pick     = lowest_set(free_q);
  assign busy_cnt = zeros_count(free_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= (free_q | rel_mask) & ~alloc_mask;
  end

  AST_ALLOC_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> any_free); // R10
  AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !free_q[$past(pick)]); // R10
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> free_q[$past(rel_tag)]); // R11
endmodule

// File: rtl/blkrd_issuer.sv
module blkrd_issuer
  import blkrd_pkg::*;
#(
  parameter int LINE_W  = 7,
  parameter int OBUF_N  = 4,
  parameter int COH_N   = 2,
  parameter int TAGS    = 8,
  parameter int RDY_LAG = 2,
  parameter int CNT_W   = $clog2(TAGS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   miss_valid,
  output logic                   miss_ready,
  input  logic [PA_W-1:0]        miss_addr,
  input  logic [1:0]             miss_cause,
  input  logic [3:0]             miss_target,
  input  logic                   miss_way,
  input  logic [1:0]             miss_state,
  input  logic                   master_state,
  input  logic                   rd_rdy_n,
  input  logic [OBUF_N-1:0]      obuf_valid,
  input  logic [OBUF_N*PA_W-1:0] obuf_addr,
  input  logic [COH_N-1:0]       coh_valid,
  input  logic [COH_N*PA_W-1:0]  coh_addr,
  input  logic [CNT_W-1:0]       req_max,
  input  logic                   cmp_valid,
  input  logic [2:0]             cmp_tag,
  output logic [CMD_W-1:0]       sys_cmd,
  output logic [AD_W-1:0]        sys_ad,
  output logic                   sys_val_n,
  output logic                   inv_en,
  output logic [PA_W-1:0]        inv_addr,
  output logic                   inv_way,
  output logic                   wb_en,
  output logic [PA_W-1:0]        wb_addr,
  output logic                   wb_way
);
  localparam int TAG_W = $clog2(TAGS);

  // Named internal events
  logic             rdy_ok;
  logic             obuf_hit;
  logic             coh_hit;
  logic             tag_free;
  logic             under_limit;
  logic             can_issue;
  logic             fire;
  logic [TAG_W-1:0] tag_pick;
  logic [CNT_W-1:0] busy_cnt;

  blkrd_rdy_hist #(.LAG(RDY_LAG)) u_rdy (
    .clk(clk), .rst_n(rst_n), .rdy_n(rd_rdy_n), .rdy_ok(rdy_ok)
  );

  blkrd_conflict #(.PA_W(PA_W), .LINE_W(LINE_W), .N(OBUF_N)) u_obuf_cmp (
    .probe(miss_addr), .vld(obuf_valid), .addrs(obuf_addr), .hit(obuf_hit)
  );

  blkrd_conflict #(.PA_W(PA_W), .LINE_W(LINE_W), .N(COH_N)) u_coh_cmp (
    .probe(miss_addr), .vld(coh_valid), .addrs(coh_addr), .hit(coh_hit)
  );

  blkrd_tag_pool #(.TAGS(TAGS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .alloc(fire),
    .rel_valid(cmp_valid), .rel_tag(cmp_tag[TAG_W-1:0]),
    .any_free(tag_free), .pick(tag_pick), .busy_cnt(busy_cnt)
  );

  assign under_limit = busy_cnt < req_max;
  assign can_issue   = master_state && rdy_ok && !obuf_hit && !coh_hit
                       && under_limit && tag_free;
  assign miss_ready  = can_issue;
  assign fire        = miss_valid && can_issue;

  // Cache-side effects in the acceptance cycle, ahead of the bus cycle.
  assign inv_en   = fire;
  assign inv_addr = miss_addr;
  assign inv_way  = miss_way;
  assign wb_en    = fire && (line_state_e'(miss_state) == LS_DIRTY_EX);
  assign wb_addr  = miss_addr;
  assign wb_way   = miss_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_val_n <= 1'b1;
      sys_cmd   <= '0;
      sys_ad    <= '0;
    end else if (fire) begin
      sys_val_n <= 1'b0;
      sys_cmd   <= cmd_word(3'(tag_pick), miss_cause, miss_state);
      sys_ad    <= ad_word(miss_target, miss_way, miss_addr);
    end else begin
      sys_val_n <= 1'b1;
      sys_cmd   <= '0;
      sys_ad    <= '0;
    end
  end

  AST_CMD_MARKERS: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_val_n |-> (!sys_cmd[11] && sys_cmd[0] && sys_cmd[7:5] == CMD_BLOCK_READ)); // R2
  AST_AD_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_val_n |-> (sys_ad[59:58] == 2'b00 && sys_ad[56:40] == '0)); // R3
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_val_n |-> (sys_cmd == '0 && sys_ad == '0)); // R4
  AST_ONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !sys_val_n); // R4
  AST_RDY_TWO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_val_n |-> $past(rd_rdy_n, 2) == 1'b0); // R5
  AST_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_val_n |-> $past(master_state)); // R6
  AST_OBUF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    obuf_hit |-> !miss_ready); // R7
  AST_COH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    coh_hit |-> !miss_ready); // R8
  AST_NO_OVER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_val_n |-> $past(busy_cnt) < $past(req_max)); // R9
  AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (inv_en && miss_state == 2'b11)); // R12
endmodule

// File: tb/test_blkrd_issuer.sv
module test_blkrd_issuer;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic miss_valid;
  logic miss_ready;
  logic [39:0] miss_addr;
  logic [1:0] miss_cause;
  logic [3:0] miss_target;
  logic miss_way;
  logic [1:0] miss_state;
  logic master_state;
  logic rd_rdy_n;
  logic [3:0] obuf_valid;
  logic [159:0] obuf_addr;
  logic [1:0] coh_valid;
  logic [79:0] coh_addr;
  logic [3:0] req_max;
  logic cmp_valid;
  logic [2:0] cmp_tag;
  logic [11:0] sys_cmd;
  logic [63:0] sys_ad;
  logic sys_val_n;
  logic inv_en, inv_way, wb_en, wb_way;
  logic [39:0] inv_addr, wb_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit [7:0] mfree;

  always #(CLK_P/2) clk = ~clk;

  blkrd_issuer i_blkrd_issuer (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_cause(miss_cause), .miss_target(miss_target),
    .miss_way(miss_way), .miss_state(miss_state), .master_state(master_state),
    .rd_rdy_n(rd_rdy_n), .obuf_valid(obuf_valid), .obuf_addr(obuf_addr),
    .coh_valid(coh_valid), .coh_addr(coh_addr), .req_max(req_max),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .sys_cmd(sys_cmd), .sys_ad(sys_ad),
    .sys_val_n(sys_val_n), .inv_en(inv_en), .inv_addr(inv_addr), .inv_way(inv_way),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_way(wb_way)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < 8; i++) if (mfree[i]) return i;
    return -1;
  endfunction

  function automatic int used_cnt();
    int n = 0;
    for (int i = 0; i < 8; i++) if (!mfree[i]) n++;
    return n;
  endfunction

  function automatic logic [11:0] exp_cmd(input int tag, input logic [1:0] c,
                                          input logic [1:0] s);
    logic [11:0] w = 12'h001;
    w = w | (12'(tag) << 8) | (12'h2 << 5) | (12'(c) << 3) | (12'(s) << 1);
    return w;
  endfunction

  function automatic logic [63:0] exp_ad(input logic [3:0] t, input logic w,
                                         input logic [39:0] a);
    return (64'(t) << 60) | (64'(w) << 57) | 64'(a);
  endfunction

  task automatic present(input logic [39:0] a, input logic [1:0] c,
                         input logic [3:0] t, input logic w, input logic [1:0] s);
    miss_valid = 1'b1; miss_addr = a; miss_cause = c;
    miss_target = t; miss_way = w; miss_state = s;
  endtask

  // Called at a negedge; accepts one miss and checks both cycles.
  task automatic issue_chk(input string req, input logic [39:0] a,
                           input logic [1:0] c, input logic [3:0] t,
                           input logic w, input logic [1:0] s);
    int tag;
    tag = low_free();
    present(a, c, t, w, s);
    #1;
    chk(miss_ready === 1'b1, "R13", {req, " ready"}, 64'(miss_ready), 64'd1);
    chk(inv_en === 1'b1 && inv_addr === a && inv_way === w, "R12", "invalidate",
        64'(inv_addr), 64'(a));
    chk(wb_en === (s == 2'b11) && wb_addr === a && wb_way === w, "R12", "writeback",
        64'(wb_en), 64'(s == 2'b11));
    @(negedge clk);
    miss_valid = 1'b0;
    chk(sys_val_n === 1'b0, "R4", "strobe low after accept", 64'(sys_val_n), 64'd0);
    chk(sys_cmd === exp_cmd(tag, c, s), "R2", {req, " cmd / R10 tag"},
        64'(sys_cmd), 64'(exp_cmd(tag, c, s)));
    chk(sys_ad === exp_ad(t, w, a), "R3", "address word", sys_ad, exp_ad(t, w, a));
    mfree[tag] = 1'b0;
    @(negedge clk);
    chk(sys_val_n === 1'b1 && sys_cmd === 12'd0 && sys_ad === 64'd0, "R4",
        "single cycle then idle", 64'(sys_cmd), 64'd0);
  endtask

  task automatic blocked_chk(input string req, input logic [39:0] a);
    present(a, 2'd0, 4'h1, 1'b0, 2'b01);
    #1;
    chk(miss_ready === 1'b0, req, "ready while blocked", 64'(miss_ready), 64'd0);
    chk(inv_en === 1'b0, "R13", "no invalidate while blocked", 64'(inv_en), 64'd0);
    @(negedge clk);
    miss_valid = 1'b0;
    chk(sys_val_n === 1'b1, "R13", "bus idle while blocked", 64'(sys_val_n), 64'd1);
  endtask

  task automatic complete(input int tag);
    cmp_valid = 1'b1; cmp_tag = 3'(tag);
    @(negedge clk);
    cmp_valid = 1'b0;
    mfree[tag] = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(sys_val_n === 1'b1 && sys_cmd === 12'd0 && sys_ad === 64'd0, "R1",
        "idle bus after reset", 64'(sys_val_n), 64'd1);
    present(40'h0, 2'd0, 4'h0, 1'b0, 2'b00);
    #1;
    chk(miss_ready === 1'b0, "R1", "no ready before history", 64'(miss_ready), 64'd0);
    @(negedge clk);
    miss_valid = 1'b0;
    chk(sys_val_n === 1'b1, "R5", "no issue without history", 64'(sys_val_n), 64'd1);
  endtask

  task automatic t_basic();
    issue_chk("R2", 40'h12_3456_7880, 2'd1, 4'hA, 1'b1, 2'b10);
    issue_chk("R3", 40'hFF_FFFF_FFC0, 2'd3, 4'h5, 1'b0, 2'b11);
    issue_chk("R10", 40'h00_0000_0100, 2'd2, 4'hF, 1'b1, 2'b01);
  endtask

  task automatic t_release();
    complete(1);
    issue_chk("R11", 40'h01_0000_0000, 2'd0, 4'h3, 1'b0, 2'b00);
    complete(0); complete(1); complete(2);
  endtask

  task automatic t_rdy_lag();
    rd_rdy_n = 1'b1;
    @(negedge clk);
    rd_rdy_n = 1'b0;
    blocked_chk("R5", 40'h02_0000_0000);
    issue_chk("R5", 40'h02_0000_0000, 2'd1, 4'h2, 1'b0, 2'b01);
  endtask

  task automatic t_master();
    master_state = 1'b0;
    blocked_chk("R6", 40'h03_0000_0000);
    master_state = 1'b1;
    issue_chk("R6", 40'h03_0000_0000, 2'd0, 4'h2, 1'b1, 2'b10);
  endtask

  task automatic t_obuf();
    obuf_addr = '0;
    obuf_addr[2*40 +: 40] = 40'h04_0000_0080;
    obuf_valid = 4'b0100;
    blocked_chk("R7", 40'h04_0000_00C5);
    issue_chk("R7", 40'h04_0000_0100, 2'd1, 4'h6, 1'b0, 2'b00);
    obuf_valid = 4'b0000;
    issue_chk("R7", 40'h04_0000_0085, 2'd1, 4'h6, 1'b0, 2'b00);
  endtask

  task automatic t_coh();
    coh_addr = '0;
    coh_addr[1*40 +: 40] = 40'h05_1234_5600;
    coh_valid = 2'b10;
    blocked_chk("R8", 40'h05_1234_567F);
    issue_chk("R8", 40'h05_1234_5680, 2'd2, 4'h7, 1'b1, 2'b11);
    coh_valid = 2'b00;
  endtask

  task automatic t_limit();
    int b;
    b = used_cnt();
    req_max = 4'(b);
    blocked_chk("R9", 40'h06_0000_0000);
    req_max = 4'(b + 1);
    issue_chk("R9", 40'h06_0000_0000, 2'd0, 4'h1, 1'b0, 2'b01);
    req_max = 4'd8;
  endtask

  task automatic t_full();
    while (low_free() >= 0)
      issue_chk("R10", 40'h07_0000_0000 + 40'(used_cnt()) * 40'h80, 2'd3, 4'h9, 1'b1, 2'b10);
    blocked_chk("R10", 40'h08_0000_0000);
    complete(3);
    issue_chk("R11", 40'h08_0000_0000, 2'd1, 4'h4, 1'b0, 2'b11);
    for (int i = 0; i < 8; i++) complete(i);
  endtask

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0; miss_cause = '0;
    miss_target = '0; miss_way = 1'b0; miss_state = '0; master_state = 1'b1;
    rd_rdy_n = 1'b0; obuf_valid = '0; obuf_addr = '0; coh_valid = '0;
    coh_addr = '0; req_max = 4'd8; cmp_valid = 1'b0; cmp_tag = '0;
    mfree = 8'hFF;
    t_reset();
    t_basic();
    t_release();
    t_rdy_lag();
    t_master();
    t_obuf();
    t_coh();
    t_limit();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule